// File: doc/BRIEF.md
# LCD Timing Generator

This block produces the horizontal sync, vertical sync and display-enable strobes for a raster LCD panel. Software programs the frame geometry as cumulative positions counted from the start of each sync pulse: where sync ends, where the visible area begins, how many pixels are visible, and the total length of a line or frame. A pixel counter and a line counter sweep these positions. The strobes are decoded from the two counters and sent to the panel at a selectable polarity.

The current line number can be read through the register port. Three interrupt causes are latched in a status register: start of vertical sync, start of the visible area, and arrival at a programmable match line. Each cause has its own enable bit, which decides whether the cause is latched, and its own mask bit, which decides whether a latched cause drives the interrupt pin. A graphics-enable bit starts and stops the whole raster. Software clears it before it rewrites the geometry. While it is clear, the counters rest at zero and the panel sees inactive strobes.

Top module: `lcd_timing_gen`

## Requirements
- R1: With enable set, the pixel counter steps by one per clock and returns to 0 after value HTOT-1, so a line lasts HTOT clocks. Horizontal sync is active while the pixel counter is below HSE (register 2). HTOT is register 4.
- R2: The line counter steps by one on each pixel-counter wrap and returns to 0 after line VTOT-1 (register 9). Vertical sync is active while the line counter is below VSE (register 6).
- R3: Display enable is high only when enable is set, the pixel counter is in [HDS, HDS+HACT) and the line counter is in [VDS, VMATCH). HDS, HACT, VDS and VMATCH are registers 3, 5, 7 and 8.
- R4: Reading register 10 returns the current line counter value.
- R5: Status register 11 is updated one clock after the event. Bit 0 is latched when the counters stand at pixel 0 of line 0. Bit 1 is latched at pixel 0 of line VDS. Bit 2 is latched at pixel 0 of line VMATCH. A bit is latched only if the same bit of the enable register 12 is set.
- R6: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. A new event in the same clock takes priority over the clear.
- R7: The interrupt pin is high exactly when some status bit is set and the same bit of the mask register 13 is zero.
- R8: Bit 0 of the polarity register 1 makes horizontal sync active-high when set and active-low when clear. Bit 1 does the same for vertical sync.
- R9: While bit 0 of control register 0 (graphics enable) is clear, both counters are held at 0, both syncs are inactive, display enable is low and no status bit is latched.
- R10: After reset, every register reads 0, both sync pins are high, and display enable and the interrupt pin are low.
- R11: Registers 0 to 9, 12 and 13 read back the last value written, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Display enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The raster is first run with a small geometry whose porches are all non-zero, so that every sync, porch and visible boundary falls on a different pixel and a different line. It is then run with a second geometry that has no front porches and a match line equal to the frame total. This second run shows whether the last visible pixel and line touch the wrap correctly. Polarity flips, masking, write-one-to-clear (including a clear that lands on a new event) and a disable in the middle of a frame are applied while a behavioural model tracks both counters. The model separates a counter that wraps one clock early or late from one that runs correctly, and it separates latching a cause from reporting it on the pin.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
    parameter int unsigned CW   = 16;
    parameter int unsigned DW   = 16;
    parameter int unsigned AW   = 4;
    parameter int unsigned NIRQ = 3;

    localparam int unsigned IRQ_VSYNC = 0;
    localparam int unsigned IRQ_DISP  = 1;
    localparam int unsigned IRQ_MATCH = 2;

    typedef enum logic [AW-1:0] {
        A_CTRL   = 4'd0,
        A_POL    = 4'd1,
        A_HSE    = 4'd2,
        A_HDS    = 4'd3,
        A_HTOT   = 4'd4,
        A_HACT   = 4'd5,
        A_VSE    = 4'd6,
        A_VDS    = 4'd7,
        A_VMATCH = 4'd8,
        A_VTOT   = 4'd9,
        A_LINE   = 4'd10,
        A_STAT   = 4'd11,
        A_IEN    = 4'd12,
        A_IMASK  = 4'd13
    } reg_addr_e;

    typedef struct packed {
        logic          en;
        logic [1:0]    pol;
        logic [CW-1:0] hse;
        logic [CW-1:0] hds;
        logic [CW-1:0] htot;
        logic [CW-1:0] hact;
        logic [CW-1:0] vse;
        logic [CW-1:0] vds;
        logic [CW-1:0] vmatch;
        logic [CW-1:0] vtot;
    } timing_cfg_t;

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } scan_pos_t;

    // true when the next increment would reach the programmed total
    function automatic logic at_last(input logic [CW-1:0] cnt, input logic [CW-1:0] total);
        return ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, total};
    endfunction

    // half-open window test on widened operands
    function automatic logic in_span(input logic [CW:0] cnt, input logic [CW:0] lo,
                                     input logic [CW:0] hi);
        return (cnt >= lo) && (cnt < hi);
    endfunction

    // apply output polarity: pol=1 active-high, pol=0 active-low
    function automatic logic to_pin(input logic active, input logic pol);
        return pol ? active : ~active;
    endfunction
endpackage

// File: rtl/lcdtg_regs.sv
module lcdtg_regs
    import lcdtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [CW-1:0]   cur_line,
    input  logic [NIRQ-1:0] status,
    output timing_cfg_t     cfg,
    output logic [NIRQ-1:0] ien,
    output logic [NIRQ-1:0] imask,
    output logic [NIRQ-1:0] stat_clr,
    output logic [DW-1:0]   rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            ien   <= '0;
            imask <= '0;
        end else if (we) begin
            case (sel)
                A_CTRL:   cfg.en     <= wdata[0];
                A_POL:    cfg.pol    <= wdata[1:0];
                A_HSE:    cfg.hse    <= wdata[CW-1:0];
                A_HDS:    cfg.hds    <= wdata[CW-1:0];
                A_HTOT:   cfg.htot   <= wdata[CW-1:0];
                A_HACT:   cfg.hact   <= wdata[CW-1:0];
                A_VSE:    cfg.vse    <= wdata[CW-1:0];
                A_VDS:    cfg.vds    <= wdata[CW-1:0];
                A_VMATCH: cfg.vmatch <= wdata[CW-1:0];
                A_VTOT:   cfg.vtot   <= wdata[CW-1:0];
                A_IEN:    ien        <= wdata[NIRQ-1:0];
                A_IMASK:  imask      <= wdata[NIRQ-1:0];
                default:  ;
            endcase
        end
    end

    assign stat_clr = (we && sel == A_STAT) ? wdata[NIRQ-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (sel)
            A_CTRL:   rdata = DW'(cfg.en);
            A_POL:    rdata = DW'(cfg.pol);
            A_HSE:    rdata = DW'(cfg.hse);
            A_HDS:    rdata = DW'(cfg.hds);
            A_HTOT:   rdata = DW'(cfg.htot);
            A_HACT:   rdata = DW'(cfg.hact);
            A_VSE:    rdata = DW'(cfg.vse);
            A_VDS:    rdata = DW'(cfg.vds);
            A_VMATCH: rdata = DW'(cfg.vmatch);
            A_VTOT:   rdata = DW'(cfg.vtot);
            A_LINE:   rdata = DW'(cur_line);
            A_STAT:   rdata = DW'(status);
            A_IEN:    rdata = DW'(ien);
            A_IMASK:  rdata = DW'(imask);
            default:  rdata = '0;
        endcase
    end

    // R11: a write lands in the addressed register on the next clock
    p_wr_lands_r11: assert property (@(posedge clk) disable iff (rst)
        (we && sel == A_HTOT) |=> (cfg.htot == $past(wdata[CW-1:0])));
endmodule

// File: rtl/lcdtg_scan.sv
module lcdtg_scan
    import lcdtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  timing_cfg_t     cfg,
    output scan_pos_t       pos,
    output logic            hs_pin,
    output logic            vs_pin,
    output logic            de,
    output logic [NIRQ-1:0] events
);
    logic h_last, v_last;
    assign h_last = at_last(pos.h, cfg.htot);
    assign v_last = at_last(pos.v, cfg.vtot);

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            pos <= '0;
        end else if (h_last) begin
            pos.h <= '0;
            pos.v <= v_last ? '0 : pos.v + 1'b1;
        end else begin
            pos.h <= pos.h + 1'b1;
        end
    end

    logic hs_act, vs_act, h_vis, v_vis;
    assign hs_act = cfg.en && (pos.h < cfg.hse);
    assign vs_act = cfg.en && (pos.v < cfg.vse);
    assign h_vis  = in_span({1'b0, pos.h}, {1'b0, cfg.hds},
                            {1'b0, cfg.hds} + {1'b0, cfg.hact});
    assign v_vis  = in_span({1'b0, pos.v}, {1'b0, cfg.vds}, {1'b0, cfg.vmatch});
    assign de     = cfg.en && h_vis && v_vis;
    assign hs_pin = to_pin(hs_act, cfg.pol[0]);
    assign vs_pin = to_pin(vs_act, cfg.pol[1]);

    logic line_head;
    assign line_head = cfg.en && (pos.h == '0);
    always_comb begin
        events            = '0;
        events[IRQ_VSYNC] = line_head && (pos.v == '0);
        events[IRQ_DISP]  = line_head && (pos.v == cfg.vds);
        events[IRQ_MATCH] = line_head && (pos.v == cfg.vmatch);
    end

    // R9: counters move away from zero only while enabled
    p_hold_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg.en) |-> (pos.h == '0 && pos.v == '0));
    // R2: the line counter changes only on a pixel-counter wrap
    p_line_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pos.v != $past(pos.v)) |-> ($past(h_last) || !$past(cfg.en)));
    // R1: the pixel counter either steps by one or returns to zero
    p_pix_step_r1: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.en) |-> (pos.h == '0 || pos.h == $past(pos.h) + 1'b1));
endmodule

// File: rtl/lcdtg_irq.sv
module lcdtg_irq
    import lcdtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] events,
    input  logic [NIRQ-1:0] ien,
    input  logic [NIRQ-1:0] imask,
    input  logic [NIRQ-1:0] clr,
    output logic [NIRQ-1:0] status,
    output logic            irq
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_cause
        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= (status[i] & ~clr[i]) | (events[i] & ien[i]);
        end
    end

    assign irq = |(status & ~imask);

    // R5: an enabled event is latched on the next clock
    p_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (events[IRQ_DISP] && ien[IRQ_DISP]) |=> status[IRQ_DISP]);
    // R6: a clear with no competing event empties the bit
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (clr[IRQ_VSYNC] && !(events[IRQ_VSYNC] && ien[IRQ_VSYNC])) |=> !status[IRQ_VSYNC]);
    // R5: with the enable clear a bit cannot newly rise
    p_no_rise_r5: assert property (@(posedge clk) disable iff (rst)
        !ien[IRQ_MATCH] |=> !$rose(status[IRQ_MATCH]));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          irq_o
);
    timing_cfg_t     cfg;
    scan_pos_t       pos;
    logic [NIRQ-1:0] ien, imask, clr, status, events;

    lcdtg_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cur_line(pos.v), .status(status), .cfg(cfg), .ien(ien), .imask(imask),
        .stat_clr(clr), .rdata(reg_rdata)
    );

    lcdtg_scan u_scan (
        .clk(clk), .rst(rst), .cfg(cfg), .pos(pos), .hs_pin(hsync_o),
        .vs_pin(vsync_o), .de(de_o), .events(events)
    );

    lcdtg_irq u_irq (
        .clk(clk), .rst(rst), .events(events), .ien(ien), .imask(imask),
        .clr(clr), .status(status), .irq(irq_o)
    );

    // R3: visible pixels come only from lines inside the vertical window
    p_de_lines_r3: assert property (@(posedge clk) disable iff (rst)
        de_o |-> (pos.v >= cfg.vds && pos.v < cfg.vmatch));
    // R9: no visible output while graphics is off
    p_de_off_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> !de_o);
endmodule

// File: tb/lcd_timing_gen_bench.sv
module lcd_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd10;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        hsync_o, vsync_o, de_o, irq_o;

    always #2.5 clk = ~clk;

    lcd_timing_gen u_lcd_timing_gen (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    int m_en, m_pol, m_ien, m_imask, m_stat, hc, vc;
    int m_r[16];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int ev, nh, nv, clr;
        if (rst) begin
            m_en = 0; m_pol = 0; m_ien = 0; m_imask = 0; m_stat = 0; hc = 0; vc = 0;
            for (int i = 0; i < 16; i++) m_r[i] = 0;
        end else begin
            ev = 0;
            if (m_en != 0 && hc == 0) begin
                if (vc == 0)     ev |= 1;
                if (vc == m_r[7]) ev |= 2;
                if (vc == m_r[8]) ev |= 4;
            end
            nh = hc; nv = vc;
            if (m_en == 0) begin nh = 0; nv = 0; end
            else if (hc + 1 >= m_r[4]) begin
                nh = 0;
                nv = (vc + 1 >= m_r[9]) ? 0 : vc + 1;
            end else nh = hc + 1;
            clr = (reg_we && reg_addr == 11) ? (reg_wdata & 7) : 0;
            m_stat = (m_stat & ~clr) | (ev & m_ien);
            hc = nh; vc = nv;
            if (reg_we) begin
                case (reg_addr)
                    0: m_en = reg_wdata & 1;
                    1: m_pol = reg_wdata & 3;
                    12: m_ien = reg_wdata & 7;
                    13: m_imask = reg_wdata & 7;
                    default: if (reg_addr >= 2 && reg_addr <= 9) m_r[reg_addr] = reg_wdata;
                endcase
            end
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            0: return m_en;
            1: return m_pol;
            10: return vc;
            11: return m_stat;
            12: return m_ien;
            13: return m_imask;
            default: return (a >= 2 && a <= 9) ? m_r[a] : 0;
        endcase
    endfunction

    always @(negedge clk) begin
        bit hs_a, vs_a, de_e, irq_e;
        if (!rst && !done) begin
            hs_a  = (m_en != 0) && (hc < m_r[2]);
            vs_a  = (m_en != 0) && (vc < m_r[6]);
            de_e  = (m_en != 0) && hc >= m_r[3] && hc < m_r[3] + m_r[5]
                    && vc >= m_r[7] && vc < m_r[8];
            irq_e = (m_stat & ~m_imask & 7) != 0;
            check(hsync_o == (m_pol[0] ? hs_a : !hs_a), "R1/R8 hsync", hsync_o, m_pol[0] ? hs_a : !hs_a);
            check(vsync_o == (m_pol[1] ? vs_a : !vs_a), "R2/R8 vsync", vsync_o, m_pol[1] ? vs_a : !vs_a);
            check(de_o == de_e, "R3 display enable", de_o, de_e);
            check(irq_o == irq_e, "R7 interrupt pin", irq_o, irq_e);
            if (reg_addr == 10)
                check(reg_rdata == exp_rd(10), "R4 line number", reg_rdata, exp_rd(10));
            else if (reg_addr == 11)
                check(reg_rdata == exp_rd(11), "R5 R6 status", reg_rdata, exp_rd(11));
            else
                check(reg_rdata == exp_rd(reg_addr), "R11 readback", reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 4'd10;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic geometry(input int hse, input int hds, input int hact, input int htot,
                            input int vse, input int vds, input int vm, input int vtot);
        wr(0, 0);
        wr(2, hse); wr(3, hds); wr(5, hact); wr(4, htot);
        wr(6, vse); wr(7, vds); wr(8, vm); wr(9, vtot);
        wr(0, 1);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        #1;
        // R10: reset state
        check(hsync_o == 1'b1, "R10 hsync after reset", hsync_o, 1);
        check(vsync_o == 1'b1, "R10 vsync after reset", vsync_o, 1);
        check(de_o == 1'b0, "R10 de after reset", de_o, 0);
        check(irq_o == 1'b0, "R10 irq after reset", irq_o, 0);
        check(reg_rdata == 16'd0, "R10 line after reset", reg_rdata, 0);

        wr(12, 7);
        geometry(2, 4, 5, 12, 1, 3, 6, 8);
        idle(250);
        wr(1, 3);                     // R8 both active-high
        idle(120);
        wr(1, 1);
        idle(60);
        wr(13, 1);                    // R7 mask vsync-start cause
        idle(120);
        wr(11, 7);                    // R6 clear all
        idle(40);
        wr(11, 2);
        idle(100);
        wr(13, 0);
        idle(10);
        wr(0, 0);                     // R9 disable mid-frame
        idle(40);
        wr(11, 7);
        idle(40);
        wr(12, 4);
        geometry(3, 5, 8, 17, 2, 4, 9, 11);
        idle(400);
        // R6: hammer clears across event edges
        for (int k = 0; k < 40; k++) wr(11, 7);
        idle(20);
        wr(12, 7);
        geometry(1, 3, 10, 13, 1, 2, 5, 5);   // zero front porches, match = total
        idle(300);
        // R11: readback of every address
        for (int a = 0; a < 16; a++) begin
            @(posedge clk); #1;
            reg_addr = 4'(a);
            idle(2);
        end
        reg_addr = 4'd10;
        idle(5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule